// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input pins of a 32-pin general-purpose I/O controller and turns selected transitions or levels on them into latched interrupt status. Each pin has its own set of configuration bits: an enable, a mask, a trigger-kind select (edge or level), a polarity select and a dual-edge select. These bits sit in separate 32-bit registers behind a simple single-cycle register bus. Software reads the latched status in two views, raw and masked. It acknowledges edge events by writing ones to a clear register.

Pin inputs are brought into the clock domain through a two-flop synchroniser. An edge is a difference between two consecutive synchronised samples. A single registered interrupt line goes to the parent interrupt controller. It is high while any pin has status that is not masked.

Top module: `gpio_irq_detect`

## Requirements
- R1: The enable (0x20), mask (0x2C), trigger-kind (0x34), dual-edge (0x38) and polarity (0x3C) registers read back the value last written at their offsets. A write takes effect at the next clock edge, and read data appears one cycle after the address is presented.
- R2: With trigger-kind bit 0 (edge), dual-edge bit 0 and polarity bit 0, a 0-to-1 transition of the synchronised pin sets its raw status bit (read at 0x24). A 1-to-0 transition does not set it.
- R3: With trigger-kind bit 0, dual-edge bit 0 and polarity bit 1, a 1-to-0 transition sets raw status. A 0-to-1 transition does not set it.
- R4: With trigger-kind bit 0 and dual-edge bit 1, either transition sets raw status, whatever the polarity bit.
- R5: With trigger-kind bit 1 (level), raw status is 1 exactly while the pin is at its active level: high for polarity 0, low for polarity 1. Writing the clear register does not drop it while that level persists.
- R6: A pin whose enable bit is 0 never sets its raw status.
- R7: Writing 1 to a bit of the clear register (0x30) clears that pin's latched edge status. Writing 0 to a bit leaves that bit's status unchanged.
- R8: If an edge event for a pin is detected in the same cycle as a clear write for that pin, the status stays set.
- R9: The masked status register (0x28) reads raw status AND NOT mask.
- R10: The interrupt output is the OR of all masked status bits, registered one cycle after the status. A pin transition shows in raw status after the third rising clock edge following it, and on the interrupt output after the fourth.
- R11: After reset, all registers read 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous pin levels |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A pin change driven between clock edges reaches raw status after the third rising edge and the interrupt output after the fourth. The latency test samples between edges three and four and again after edge four, to pin down those exact cycles. The edge-against-clear test holds the clear write in the one cycle where the edge is detected, which is the cycle between edges two and three. All other checks wait at least six cycles after a pin change before reading. Every register read presents the address and samples the read data one cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_KIND   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_DUAL   = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_POL    = 8'h3C;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] async_in,
    output logic [NPINS-1:0] sync_out
);
    logic [NPINS-1:0] stage_d [STAGES];
    logic [NPINS-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [NPINS-1:0]  en,
    output logic [NPINS-1:0]  mask,
    output logic [NPINS-1:0]  kind,
    output logic [NPINS-1:0]  dual,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  clr
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] kind;
        logic [NPINS-1:0] dual;
        logic [NPINS-1:0] pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NPINS-1:0] wbits;

    always_comb begin
        wbits = wdata[NPINS-1:0];
        cfg_d = cfg_q;
        clr   = '0;
        if (wr) begin
            case (addr)
                OFF_ENABLE: cfg_d.en   = wbits;
                OFF_MASK:   cfg_d.mask = wbits;
                OFF_KIND:   cfg_d.kind = wbits;
                OFF_DUAL:   cfg_d.dual = wbits;
                OFF_POL:    cfg_d.pol  = wbits;
                OFF_CLEAR:  clr        = wbits;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en   = cfg_q.en;
    assign mask = cfg_q.mask;
    assign kind = cfg_q.kind;
    assign dual = cfg_q.dual;
    assign pol  = cfg_q.pol;

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_ENABLE) |=> (en == $past(wbits)));
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] smp,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] kind,
    input  logic [NPINS-1:0] dual,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] status;
    } core_t;

    core_t core_d, core_q;
    logic [NPINS-1:0] rise, fall, edge_hit, active;

    always_comb begin
        rise     = smp & ~core_q.prev;
        fall     = ~smp & core_q.prev;
        edge_hit = (dual & (rise | fall))
                 | (~dual & ~pol & rise)
                 | (~dual & pol & fall);
        active   = smp ^ pol;
        core_d.prev   = smp;
        core_d.status = (kind & en & active)
                      | (~kind & ((core_q.status & ~clr) | (en & edge_hit)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign status = core_q.status;

    assert_disabled_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(en) & ~$past(status)) == '0));

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr & ~kind & ~edge_hit)) == '0));

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status & $past(~kind & en & edge_hit)) == '0));

    assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status & $past(kind & en & active & status)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_out
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          irq;
    } top_t;

    top_t top_d, top_q;
    logic [NPINS-1:0] smp, en, mask, kind, dual, pol, clr, raw, masked;

    function automatic logic [DW-1:0] widen(input logic [NPINS-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    gpio_irq_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(smp)
    );

    gpio_irq_cfg #(.NPINS(NPINS), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .en(en), .mask(mask), .kind(kind),
        .dual(dual), .pol(pol), .clr(clr)
    );

    gpio_irq_core #(.NPINS(NPINS)) u_core (
        .clk(clk), .rst_n(rst_n), .smp(smp), .en(en), .kind(kind),
        .dual(dual), .pol(pol), .clr(clr), .status(raw)
    );

    always_comb begin
        masked    = raw & ~mask;
        top_d.irq = |masked;
        case (bus_addr)
            OFF_ENABLE: top_d.rdata = widen(en);
            OFF_RAW:    top_d.rdata = widen(raw);
            OFF_MASKED: top_d.rdata = widen(masked);
            OFF_MASK:   top_d.rdata = widen(mask);
            OFF_KIND:   top_d.rdata = widen(kind);
            OFF_DUAL:   top_d.rdata = widen(dual);
            OFF_POL:    top_d.rdata = widen(pol);
            default:    top_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;
    assign irq_out   = top_q.irq;

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == ($past(raw & ~mask) != '0)));

    assert_masked_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_MASKED) |=> (bus_rdata[NPINS-1:0] == ($past(raw) & ~$past(mask))));
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    localparam logic [7:0] A_EN = 8'h20, A_RAW = 8'h24, A_MSKD = 8'h28,
        A_MASK = 8'h2C, A_CLR = 8'h30, A_KIND = 8'h34, A_DUAL = 8'h38, A_POL = 8'h3C;

    // fields: kind pol dual en mask p0 p1 exp_raw exp_irq pin[4:0]
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,5'd0},   // R2 rising
        {1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,5'd6},   // R2 falling ignored
        {1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,5'd31},  // R3 falling
        {1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,5'd12},  // R3 rising ignored
        {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,5'd5},   // R4 rise
        {1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,5'd17},  // R4 fall
        {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,5'd8},   // R5 high
        {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,5'd9},   // R5 high dropped
        {1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,5'd20},  // R5 low
        {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd3},   // R6 disabled
        {1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,5'd11},  // R9 masked
        {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,5'd25}   // R5 steady high
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic zero_cfg();
        wr_reg(A_EN, '0); wr_reg(A_MASK, '0); wr_reg(A_KIND, '0);
        wr_reg(A_DUAL, '0); wr_reg(A_POL, '0); wr_reg(A_CLR, '1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] bit1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 irq", {31'd0, irq_out}, 32'd0);
        foreach (VEC[i]) begin
            if (i < 8) begin
                rd_reg(8'h20 + 8'(i * 4), r);
                chk("R11 reg", r, 32'd0);
            end
        end

        // R1 readback
        wr_reg(A_MASK, 32'h1234_5678); rd_reg(A_MASK, r); chk("R1 mask", r, 32'h1234_5678);
        wr_reg(A_KIND, 32'h0F0F_00F0); rd_reg(A_KIND, r); chk("R1 kind", r, 32'h0F0F_00F0);
        wr_reg(A_DUAL, 32'hA5A5_5A5A); rd_reg(A_DUAL, r); chk("R1 dual", r, 32'hA5A5_5A5A);
        wr_reg(A_POL,  32'hFFFF_FFFF); rd_reg(A_POL, r);  chk("R1 pol", r, 32'hFFFF_FFFF);
        wr_reg(A_POL, '0);
        wr_reg(A_EN,   32'h8000_0001); rd_reg(A_EN, r);   chk("R1 en", r, 32'h8000_0001);
        zero_cfg();

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [4:0] p;
            p = VEC[v][4:0];
            bit1 = 32'd1 << p;
            zero_cfg();
            @(negedge clk); pin_in = '0; pin_in[p] = VEC[v][8];
            wait_cyc(5);
            wr_reg(A_CLR, '1);
            if (VEC[v][13]) wr_reg(A_KIND, bit1);
            if (VEC[v][12]) wr_reg(A_POL, bit1);
            if (VEC[v][11]) wr_reg(A_DUAL, bit1);
            if (VEC[v][9])  wr_reg(A_MASK, bit1);
            if (VEC[v][10]) wr_reg(A_EN, bit1);
            wait_cyc(5);
            wr_reg(A_CLR, '1);
            @(negedge clk); pin_in[p] = VEC[v][7];
            wait_cyc(6);
            rd_reg(A_RAW, r);
            chk($sformatf("R2-R9 vector %0d raw (R2 R3 R4 R5 R6 R9)", v), {31'd0, r[p]}, {31'd0, VEC[v][6]});
            chk($sformatf("R10 vector %0d irq", v), {31'd0, irq_out}, {31'd0, VEC[v][5]});
        end

        // R7 write-one-to-clear
        zero_cfg();
        @(negedge clk); pin_in = '0;
        wait_cyc(5);
        wr_reg(A_EN, 32'h0000_0088);
        @(negedge clk); pin_in = 32'h0000_0088;
        wait_cyc(6);
        rd_reg(A_RAW, r); chk("R7 both set", r, 32'h0000_0088);
        wr_reg(A_CLR, 32'h0); rd_reg(A_RAW, r); chk("R7 zero write", r, 32'h0000_0088);
        wr_reg(A_CLR, 32'h8); rd_reg(A_RAW, r); chk("R7 clear one", r, 32'h0000_0080);

        // R5 level not clearable
        zero_cfg();
        @(negedge clk); pin_in = '0;
        wait_cyc(5);
        wr_reg(A_KIND, 32'h200); wr_reg(A_EN, 32'h200);
        @(negedge clk); pin_in = 32'h200;
        wait_cyc(6);
        wr_reg(A_CLR, 32'h200); rd_reg(A_RAW, r); chk("R5 level kept", r, 32'h200);
        @(negedge clk); pin_in = '0;
        wait_cyc(6);
        rd_reg(A_RAW, r); chk("R5 level gone", r, 32'h0);

        // R9 masked view
        zero_cfg();
        wr_reg(A_EN, 32'h14); wr_reg(A_MASK, 32'h10);
        @(negedge clk); pin_in = 32'h14;
        wait_cyc(6);
        rd_reg(A_MSKD, r); chk("R9 masked", r, 32'h4);
        rd_reg(A_RAW, r);  chk("R9 raw", r, 32'h14);
        chk("R10 irq on", {31'd0, irq_out}, 32'd1);
        wr_reg(A_MASK, 32'h14);
        wait_cyc(2);
        chk("R10 irq masked off", {31'd0, irq_out}, 32'd0);

        // R10 exact latency
        zero_cfg();
        @(negedge clk); pin_in = '0;
        wait_cyc(5);
        wr_reg(A_EN, 32'h1);
        wr_reg(A_CLR, '1);
        @(negedge clk); pin_in = 32'h1;
        wait_cyc(3);
        chk("R10 irq not before edge 4", {31'd0, irq_out}, 32'd0);
        wait_cyc(1);
        chk("R10 irq at edge 4", {31'd0, irq_out}, 32'd1);

        // R8 edge beats clear
        zero_cfg();
        @(negedge clk); pin_in = '0;
        wait_cyc(5);
        wr_reg(A_EN, 32'h1);
        wr_reg(A_CLR, '1);
        @(negedge clk); pin_in = 32'h1;
        wait_cyc(2);
        bus_addr = A_CLR; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd_reg(A_RAW, r); chk("R8 edge wins", r, 32'h1);
        wr_reg(A_CLR, 32'h1); rd_reg(A_RAW, r); chk("R7 later clear", r, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule